// File: doc/BRIEF.md
# Memory Read Port with Programming-Status Polling

This block is the read side of a byte-wide non-volatile memory model. When the chip-enable and output-enable strobes are both low, it drives the data bus. When either strobe is high, the bus is released. Both strobes arrive already sampled to the block clock, and the bus value and its drive enable leave the block registered.

While an internal programming cycle runs, the memory array cannot be read. In that time the block returns a status word instead of array data. The top bit of the status word is the inverse of the top bit of the byte written last. The next bit flips once for each new read access. All lower bits are zero. A host can poll either bit to learn when programming has finished. When the busy flag drops, reads return array data again.

Top module: `eeprom_rdport`

## Requirements
- R1: `dataOe` is high one clock after an edge at which `ceN` and `oeN` were both sampled low. It is low one clock after an edge at which either strobe was sampled high.
- R2: Whenever `dataOe` is low, `dataOut` is all zeros. This models a released bus.
- R3: When `busy` is low during an access, `dataOut` equals the `arrayData` sampled at the previous clock edge, and `arrayRdEn` is high.
- R4: When `busy` is high during an access, `dataOut[7]` equals the inverse of `lastWrMsb` sampled at the previous edge.
- R5: While `busy` is high, `dataOut[6]` inverts exactly once per access. An access starts at the first clock where both strobes are low after a clock where either was high. The bit holds steady for the whole length of an access.
- R6: A rising edge of `busy` clears the toggle state. As a result, the first access of each programming cycle reads `dataOut[6]` = 1, whatever value the toggle held before.
- R7: When `busy` is high during an access, `dataOut[5:0]` reads as zero.
- R8: When `busy` is high, `arrayData` has no effect on `dataOut`, and `arrayRdEn` stays low for any access.
- R9: After `busy` falls, reads return true array contents, including bit 7. Accesses made while `busy` is low do not change the toggle state.
- R10: While `rstN` is low, and on the first clock after it rises with no access, `dataOe` and `dataOut` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| ceN | input | 1 | Sampled chip enable, active low |
| oeN | input | 1 | Sampled output enable, active low |
| busy | input | 1 | High while an internal programming cycle runs |
| lastWrMsb | input | 1 | Bit 7 of the byte written last |
| arrayData | input | 8 | Data read from the memory array |
| arrayRdEn | output | 1 | Array read request; high only for a read while not busy |
| dataOut | output | 8 | Registered read data bus value |
| dataOe | output | 1 | Registered bus drive enable |

## Verification
The case hardest to reach is the toggle clear at the start of a programming cycle. It is only visible if the previous programming cycle left the toggle at 1. The stimulus therefore ends one busy period after an odd number of accesses. It then reads with `busy` low, and starts a new busy period, so that a missing clear would show 0 instead of 1 on bit 6. Separately, a busy rise that lands on the same clock as an access start is driven, to check that the clear and the first flip combine correctly.

// File: rtl/eeprom_rdport_pkg.sv
package eeprom_rdport_pkg;
  typedef struct packed {
    logic readActive;
    logic accessStart;
    logic pollMode;
    logic toggleBit;
  } rdStrobes_t;
endpackage

// File: rtl/eeprom_rdport_ctrl.sv
module eeprom_rdport_ctrl
  import eeprom_rdport_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ceN,
  input  logic       oeN,
  input  logic       busy,
  output rdStrobes_t strobes,
  output logic       arrayRdEn
);
  logic activeQ;
  logic busyQ;
  logic toggleQ;
  logic readActive;
  logic accessStart;
  logic busyRise;
  logic toggleNext;

  always_comb begin
    readActive  = !ceN && !oeN;
    accessStart = readActive && !activeQ;
    busyRise    = busy && !busyQ;
    toggleNext  = (busyRise ? 1'b0 : toggleQ) ^ (accessStart && busy);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      busyQ   <= 1'b0;
      toggleQ <= 1'b0;
    end else begin
      activeQ <= readActive;
      busyQ   <= busy;
      toggleQ <= toggleNext;
    end
  end

  assign strobes.readActive  = readActive;
  assign strobes.accessStart = accessStart;
  assign strobes.pollMode    = busy;
  assign strobes.toggleBit   = toggleNext;
  assign arrayRdEn           = readActive && !busy;

  AST_TOGGLE_ON_ACCESS: assert property (@(posedge clk) disable iff (!rstN)
    (toggleQ != $past(toggleQ)) |-> ($past(accessStart && busy) || $past(busyRise))); // R5
  AST_TOGGLE_CLEARED: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(busy) && !accessStart) |=> !toggleQ); // R6
  AST_NO_ARRAY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !arrayRdEn); // R8
endmodule

// File: rtl/eeprom_rdport_dp.sv
module eeprom_rdport_dp
  import eeprom_rdport_pkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int POLL_BIT   = 7,
  parameter int TOGGLE_BIT = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  rdStrobes_t        strobes,
  input  logic              lastWrMsb,
  input  logic [DATA_W-1:0] arrayData,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);
  localparam logic [DATA_W-1:0] LOW_MASK = DATA_W'((1 << TOGGLE_BIT) - 1);

  logic [DATA_W-1:0] statusWord;

  for (genvar i = 0; i < DATA_W; i++) begin : g_status
    if (i == POLL_BIT) begin : g_poll
      assign statusWord[i] = ~lastWrMsb;
    end else if (i == TOGGLE_BIT) begin : g_tog
      assign statusWord[i] = strobes.toggleBit;
    end else begin : g_zero
      assign statusWord[i] = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataOut <= '0;
      dataOe  <= 1'b0;
    end else begin
      dataOe <= strobes.readActive;
      if (!strobes.readActive)   dataOut <= '0;
      else if (strobes.pollMode) dataOut <= statusWord;
      else                       dataOut <= arrayData;
    end
  end

  AST_OE_RISE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.readActive |=> dataOe); // R1
  AST_OE_FALL: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.readActive |=> !dataOe); // R1
  AST_BUS_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !dataOe |-> (dataOut == '0)); // R2
  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (dataOe && $past(strobes.pollMode)) |-> ((dataOut & LOW_MASK) == '0)); // R7
endmodule

// File: rtl/eeprom_rdport.sv
module eeprom_rdport
  import eeprom_rdport_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              busy,
  input  logic              lastWrMsb,
  input  logic [DATA_W-1:0] arrayData,
  output logic              arrayRdEn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);
  localparam int POLL_BIT   = DATA_W - 1;
  localparam int TOGGLE_BIT = DATA_W - 2;

  rdStrobes_t strobes;

  eeprom_rdport_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .busy(busy),
    .strobes(strobes), .arrayRdEn(arrayRdEn)
  );

  eeprom_rdport_dp #(
    .DATA_W(DATA_W), .POLL_BIT(POLL_BIT), .TOGGLE_BIT(TOGGLE_BIT)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .lastWrMsb(lastWrMsb),
    .arrayData(arrayData), .dataOut(dataOut), .dataOe(dataOe)
  );
endmodule

// File: tb/eeprom_rdport_bench.sv
module eeprom_rdport_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ceN = 1'b1;
  logic       oeN = 1'b1;
  logic       busy = 1'b0;
  logic       lastWrMsb = 1'b0;
  logic [7:0] arrayData = 8'h00;
  logic       arrayRdEn;
  logic [7:0] dataOut;
  logic       dataOe;

  always #10 clk = ~clk;

  eeprom_rdport u_eeprom_rdport (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .busy(busy),
    .lastWrMsb(lastWrMsb), .arrayData(arrayData), .arrayRdEn(arrayRdEn),
    .dataOut(dataOut), .dataOe(dataOe)
  );

  typedef struct {
    logic [7:0] data;
    logic       oe;
    logic       rd;
    string      req;
  } expItem_t;

  expItem_t scoreQ[$];
  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  // reference state, derived from the requirements
  bit mActPrev = 0, mBusyPrev = 0, mTog = 0;

  task automatic drive(bit ce, bit oe, bit bsy, bit msb, logic [7:0] arr, string req);
    expItem_t it;
    bit act, start, rise, tg;
    ceN = ce; oeN = oe; busy = bsy; lastWrMsb = msb; arrayData = arr;
    act   = !ce && !oe;
    start = act && !mActPrev;
    rise  = bsy && !mBusyPrev;
    tg    = (rise ? 1'b0 : mTog) ^ (start && bsy);
    it.oe  = act;
    it.rd  = act && !bsy;
    it.data = !act ? 8'h00 : (bsy ? {~msb, tg, 6'b0} : arr);
    it.req = req;
    scoreQ.push_back(it);
    mActPrev = act; mBusyPrev = bsy; mTog = tg;
    @(negedge clk);
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #2;
      if (scoreQ.size() > 0) begin
        expItem_t e;
        e = scoreQ.pop_front();
        nChecks++;
        if (dataOut !== e.data || dataOe !== e.oe || arrayRdEn !== e.rd) begin
          nFails++;
          $display("FAIL %s: data=%h oe=%b rd=%b expected data=%h oe=%b rd=%b",
                   e.req, dataOut, dataOe, arrayRdEn, e.data, e.oe, e.rd);
        end
      end
    end
  end

  initial begin : watchdog
    #(20 * 200000);
    if (!done) begin
      nChecks++; nFails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    // R10 reset state
    nChecks++;
    if (dataOe !== 1'b0 || dataOut !== 8'h00) begin
      nFails++;
      $display("FAIL R10: data=%h oe=%b expected data=00 oe=0", dataOut, dataOe);
    end
    rstN = 1'b1;
    @(negedge clk);
    nChecks++;
    if (dataOe !== 1'b0 || dataOut !== 8'h00) begin
      nFails++;
      $display("FAIL R10: data=%h oe=%b expected data=00 oe=0", dataOut, dataOe);
    end
    drive(1, 1, 0, 0, 8'h11, "R1");
    // R3 plain reads
    drive(0, 0, 0, 0, 8'hA5, "R3");
    drive(0, 0, 0, 0, 8'hA5, "R3");
    drive(0, 0, 0, 0, 8'h3C, "R3");
    // R2 one strobe high releases bus
    drive(0, 1, 0, 0, 8'hFF, "R2");
    drive(1, 0, 0, 0, 8'hFF, "R2");
    drive(1, 1, 0, 0, 8'hFF, "R1");
    // programming starts: R4 R5 R6 R7 R8
    drive(1, 1, 1, 0, 8'h5A, "R6");
    drive(0, 0, 1, 0, 8'h5A, "R4");
    drive(0, 0, 1, 0, 8'hFF, "R5");
    drive(0, 0, 1, 0, 8'h00, "R8");
    drive(1, 1, 1, 0, 8'h00, "R2");
    drive(0, 0, 1, 0, 8'h3F, "R5");
    drive(0, 0, 1, 0, 8'h3F, "R7");
    drive(0, 1, 1, 1, 8'h3F, "R2");
    drive(0, 0, 1, 1, 8'hC3, "R4");
    drive(0, 0, 1, 1, 8'hC3, "R5");
    drive(1, 1, 1, 1, 8'hC3, "R1");
    // programming done: R9
    drive(1, 1, 0, 1, 8'h81, "R9");
    drive(0, 0, 0, 1, 8'h81, "R9");
    drive(1, 1, 0, 1, 8'h81, "R1");
    drive(0, 0, 0, 1, 8'h7E, "R9");
    drive(1, 1, 0, 1, 8'h7E, "R1");
    // new programming cycle: toggle must restart
    drive(1, 1, 1, 0, 8'h7E, "R6");
    drive(0, 0, 1, 0, 8'h7E, "R6");
    drive(1, 1, 1, 0, 8'h7E, "R5");
    drive(0, 0, 1, 0, 8'hAA, "R5");
    drive(1, 1, 0, 0, 8'hAA, "R9");
    // busy rise on the same clock as an access start
    drive(0, 0, 1, 1, 8'h55, "R6");
    drive(0, 0, 1, 1, 8'h55, "R8");
    drive(1, 1, 0, 1, 8'h55, "R1");
    drive(0, 0, 0, 0, 8'h99, "R3");
    drive(1, 1, 0, 0, 8'h99, "R2");
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule